// File: doc/BRIEF.md
# Timed Receive Stream Command Queue

This block is the front of a receive path. Software builds each streaming command by writing three setting registers: a control word, a seconds word and a ticks word. Writing the ticks word commits the staged control word, the staged seconds word and the ticks value on the bus as one entry into an eight-deep command queue. A separate write clears every error flag.

A sequencer takes commands from the head of the queue. A command with the immediate flag starts streaming at once. Any other command waits until the running time reaches the time in the command. The sequencer then passes exactly the requested number of samples to the output. A command whose time has already passed when it is taken is dropped and reported as late. When a command finishes, the chain flag decides the next step: with chain set the sequencer takes the next command, and with chain clear it goes idle. If chain is set and the queue is empty, that is an underflow.

An overrun happens when a sample arrives during streaming and the consumer is not ready. An underflow is described above. Either one halts the sequencer until software writes the clear register. Samples pass through combinationally: `outData` is `smpData`, qualified by `outValid`.

Top module: `rx_stream_cmdq`

## Requirements
- R1: A write to address 0 stages the control word and a write to address 1 stages the seconds word. A write to address 2 pushes {staged control, staged seconds, written ticks} into the queue as one entry, and `queueCount` rises by one on the next cycle.
- R2: In the control word, bit 31 is the start-immediately flag, bit 30 is the chain flag and bits 29:0 are the sample count.
- R3: A command with the immediate flag set is taken from the queue when the sequencer is idle. Samples pass from the following cycle, whatever the time.
- R4: A timed command passes samples from the first cycle in which {nowSecs,nowTicks} is greater than or equal to {command seconds, command ticks}, compared as one 64-bit value.
- R5: When a timed command is taken from the queue and its time is already below the current time, it is dropped and passes no samples. `lateErr` is set and the next queued command is taken.
- R6: While a command is streaming, `outValid` equals `smpValid`. Exactly as many samples as the count are accepted (`outValid` and `outReady` high together). A count of zero passes no sample.
- R7: When a command with chain clear completes, the sequencer becomes idle. When a command with chain set completes and the queue is not empty, the next command is taken in the same cycle.
- R8: When a command with chain set completes and the queue is empty, `underflowErr` is set and the sequencer halts: no samples pass and no commands are taken until a clear.
- R9: A sample presented while streaming with `outReady` low sets `overrunErr` and halts the sequencer until a clear.
- R10: The queue holds 8 entries. A push while it is full is ignored, `queueCount` stays at 8, and `cmdDropped` is set and stays set.
- R11: A write to address 3 clears `lateErr`, `overrunErr`, `underflowErr` and `cmdDropped`, and moves a halted sequencer back to idle.
- R12: After reset the queue is empty, all four flags are low and `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cfgWrEn | input | 1 | Setting register write strobe |
| cfgAddr | input | 2 | Setting register address (0 control, 1 seconds, 2 ticks and commit, 3 clear) |
| cfgData | input | 32 | Setting register write data |
| nowSecs | input | 32 | Running time, seconds part |
| nowTicks | input | 32 | Running time, ticks part |
| smpValid | input | 1 | Incoming sample present |
| smpData | input | 32 | Incoming sample |
| outReady | input | 1 | Consumer can take a sample |
| outValid | output | 1 | Sample passed to consumer |
| outData | output | 32 | Passed sample |
| queueCount | output | 4 | Commands waiting in the queue |
| lateErr | output | 1 | Sticky: a late command was dropped |
| overrunErr | output | 1 | Sticky: overrun, sequencer halted |
| underflowErr | output | 1 | Sticky: chained command found an empty queue |
| cmdDropped | output | 1 | Sticky: a push hit a full queue |

## Verification
The assertions assume the running time never decreases, that at most one setting write arrives per cycle, and that `smpValid` and `outReady` are known at every clock. The bench advances the ticks by one each cycle and raises the seconds only forward. It issues one register write per cycle. It never writes the clear register in the same cycle as an event that sets a flag, so the rule that a set wins over a clear is never relied on.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_SECS  = 2'd1;
  localparam logic [1:0] ADDR_TICKS = 2'd2;
  localparam logic [1:0] ADDR_CLEAR = 2'd3;

  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_RUN, SQ_HALT} seqState_t;

  typedef struct packed {
    logic popHead;
    logic loadCur;
    logic decRem;
    logic clrFlags;
  } seqStrobe_t;
endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWrEn,
  input  logic [1:0]                   cfgAddr,
  input  logic [DATA_W-1:0]            cfgData,
  input  logic [DATA_W-1:0]            nowSecs,
  input  logic [DATA_W-1:0]            nowTicks,
  input  seqStrobe_t                   strobe,
  output logic                         headValid,
  output logic                         headStartNow,
  output logic                         headLate,
  output logic                         curReached,
  output logic                         curRemZero,
  output logic                         curChain,
  output logic [$clog2(DEPTH+1)-1:0]   queueCount,
  output logic                         cmdDropped
);
  localparam int CNT_W  = DATA_W - 2;
  localparam int TIME_W = 2 * DATA_W;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int LVL_W  = $clog2(DEPTH + 1);

  typedef struct packed {
    logic              startNow;
    logic              chain;
    logic [CNT_W-1:0]  nSamp;
    logic [TIME_W-1:0] when;
  } cmdEntry_t;

  logic [DATA_W-1:0] stageCtrl, stageSecs;
  cmdEntry_t         mem [DEPTH];
  cmdEntry_t         newEntry, head;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [LVL_W-1:0]  level;
  logic [TIME_W-1:0] nowTime, curTime;
  logic [CNT_W-1:0]  curRem;
  logic              pushReq, full, doPush, pop;

  assign nowTime  = {nowSecs, nowTicks};
  assign pushReq  = cfgWrEn && (cfgAddr == ADDR_TICKS);
  assign full     = (level == LVL_W'(DEPTH));
  assign doPush   = pushReq && !full;
  assign pop      = strobe.popHead;
  assign newEntry = cmdEntry_t'({stageCtrl, stageSecs, cfgData});
  assign head     = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageCtrl <= '0;
      stageSecs <= '0;
    end else if (cfgWrEn) begin
      if (cfgAddr == ADDR_CTRL) stageCtrl <= cfgData;
      if (cfgAddr == ADDR_SECS) stageSecs <= cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + PTR_W'(1);
      if (pop)    rdPtr <= rdPtr + PTR_W'(1);
      case ({doPush, pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cmdDropped <= 1'b0;
    else       cmdDropped <= (cmdDropped && !strobe.clrFlags) || (pushReq && full);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTime  <= '0;
      curRem   <= '0;
      curChain <= 1'b0;
    end else if (strobe.loadCur) begin
      curTime  <= head.when;
      curRem   <= head.nSamp;
      curChain <= head.chain;
    end else if (strobe.decRem) begin
      curRem <= curRem - CNT_W'(1);
    end
  end

  assign headValid    = (level != '0);
  assign headStartNow = head.startNow;
  assign headLate     = head.when < nowTime;
  assign curReached   = nowTime >= curTime;
  assign curRemZero   = (curRem == '0);
  assign queueCount   = level;

  // R10: the level never passes the depth
  a_r10_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));
  // R10: a push into a full queue changes nothing and is recorded
  a_r10_full_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && full && !pop) |=> (level == $past(level)) && cmdDropped);
  // R1: an accepted push grows the queue by one
  a_r1_push_grows: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !full && !pop) |=> level == $past(level) + LVL_W'(1));
endmodule

// File: rtl/rxq_control.sv
module rxq_control
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgAddr,
  input  logic       headValid,
  input  logic       headStartNow,
  input  logic       headLate,
  input  logic       curReached,
  input  logic       curRemZero,
  input  logic       curChain,
  input  logic       smpValid,
  input  logic       outReady,
  output seqStrobe_t strobe,
  output logic       outValid,
  output logic       lateErr,
  output logic       overrunErr,
  output logic       underflowErr
);
  seqState_t st, nst;
  logic clr, active, take, ovf, popGo;
  logic setLate, setOvr, setUnd;

  assign clr    = cfgWrEn && (cfgAddr == ADDR_CLEAR);
  assign active = ((st == SQ_RUN) || ((st == SQ_WAIT) && curReached)) && !curRemZero;
  assign take   = active && smpValid && outReady;
  assign ovf    = active && smpValid && !outReady;
  assign outValid = active && smpValid;

  always_comb begin
    nst     = st;
    popGo   = 1'b0;
    setLate = 1'b0;
    setOvr  = 1'b0;
    setUnd  = 1'b0;
    strobe  = '0;
    strobe.clrFlags = clr;
    strobe.decRem   = take;
    unique case (st)
      SQ_IDLE: popGo = headValid;
      SQ_WAIT, SQ_RUN: begin
        if (ovf) begin
          setOvr = 1'b1;
          nst    = SQ_HALT;
        end else if ((st == SQ_WAIT) && curReached) begin
          nst = SQ_RUN;
        end else if ((st == SQ_RUN) && curRemZero) begin
          if (!curChain)      nst = SQ_IDLE;
          else if (headValid) popGo = 1'b1;
          else begin
            setUnd = 1'b1;
            nst    = SQ_HALT;
          end
        end
      end
      SQ_HALT: if (clr) nst = SQ_IDLE;
      default: nst = SQ_IDLE;
    endcase
    if (popGo) begin
      strobe.popHead = 1'b1;
      if (headStartNow) begin
        strobe.loadCur = 1'b1;
        nst = SQ_RUN;
      end else if (headLate) begin
        setLate = 1'b1;
        nst = SQ_IDLE;
      end else begin
        strobe.loadCur = 1'b1;
        nst = SQ_WAIT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st           <= SQ_IDLE;
      lateErr      <= 1'b0;
      overrunErr   <= 1'b0;
      underflowErr <= 1'b0;
    end else begin
      st           <= nst;
      lateErr      <= (lateErr && !clr) || setLate;
      overrunErr   <= (overrunErr && !clr) || setOvr;
      underflowErr <= (underflowErr && !clr) || setUnd;
    end
  end

  // R9: a refused sample halts the stream on the next cycle
  a_r9_overrun_halts: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> overrunErr && !outValid);
  // R8: a halted sequencer passes nothing
  a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (st == SQ_HALT) |-> !outValid && !strobe.popHead);
  // R6: the queue is only popped when it holds a command
  a_r6_pop_needs_head: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popHead |-> headValid);
  // R5: a pop that loads nothing is a late drop
  a_r5_late_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.popHead && !strobe.loadCur) |=> lateErr);
endmodule

// File: rtl/rx_stream_cmdq.sv
module rx_stream_cmdq
  import rxq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SMP_W  = 32,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWrEn,
  input  logic [1:0]                 cfgAddr,
  input  logic [DATA_W-1:0]          cfgData,
  input  logic [DATA_W-1:0]          nowSecs,
  input  logic [DATA_W-1:0]          nowTicks,
  input  logic                       smpValid,
  input  logic [SMP_W-1:0]           smpData,
  input  logic                       outReady,
  output logic                       outValid,
  output logic [SMP_W-1:0]           outData,
  output logic [$clog2(DEPTH+1)-1:0] queueCount,
  output logic                       lateErr,
  output logic                       overrunErr,
  output logic                       underflowErr,
  output logic                       cmdDropped
);
  seqStrobe_t strobe;
  logic headValid, headStartNow, headLate, curReached, curRemZero, curChain;

  rxq_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .nowSecs(nowSecs), .nowTicks(nowTicks), .strobe(strobe),
    .headValid(headValid), .headStartNow(headStartNow), .headLate(headLate),
    .curReached(curReached), .curRemZero(curRemZero), .curChain(curChain),
    .queueCount(queueCount), .cmdDropped(cmdDropped)
  );

  rxq_control u_ctl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .headValid(headValid), .headStartNow(headStartNow), .headLate(headLate),
    .curReached(curReached), .curRemZero(curRemZero), .curChain(curChain),
    .smpValid(smpValid), .outReady(outReady), .strobe(strobe),
    .outValid(outValid), .lateErr(lateErr), .overrunErr(overrunErr),
    .underflowErr(underflowErr)
  );

  assign outData = smpData;
endmodule

// File: tb/rx_stream_cmdq_bench.sv
module rx_stream_cmdq_bench;
  logic clk = 1'b0;
  logic rstN;
  logic cfgWrEn;
  logic [1:0] cfgAddr;
  logic [31:0] cfgData, nowSecs, nowTicks, smpData, outData;
  logic smpValid, outReady, outValid, lateErr, overrunErr, underflowErr, cmdDropped;
  logic [3:0] queueCount;

  always #10 clk = ~clk;

  rx_stream_cmdq u_rx_stream_cmdq (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .nowSecs(nowSecs), .nowTicks(nowTicks), .smpValid(smpValid), .smpData(smpData),
    .outReady(outReady), .outValid(outValid), .outData(outData), .queueCount(queueCount),
    .lateErr(lateErr), .overrunErr(overrunErr), .underflowErr(underflowErr),
    .cmdDropped(cmdDropped)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  string curReq = "R12";

  // reference model: 0 idle, 1 waiting, 2 streaming, 3 halted
  logic [95:0] mq[$];
  logic [31:0] mCtrl = 0, mSecs = 0, nCtrl, nSecs;
  int mSt = 0, nSt;
  logic [63:0] mTime = 0, nTime;
  int unsigned mRem = 0, nRem;
  bit mChain = 0, nChain;
  bit mLate = 0, mOvr = 0, mUnd = 0, mDrop = 0;
  bit nLate, nOvr, nUnd, nDrop, popNow, pushNow;
  logic [95:0] pushVal;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", curReq, what, act, exp);
    end
  endtask

  task automatic modelEval();
    logic [63:0] nowv = {nowSecs, nowTicks};
    bit reached = nowv >= mTime;
    bit active = ((mSt == 2) || (mSt == 1 && reached)) && (mRem != 0);
    bit expV = active && smpValid;
    bit clr = cfgWrEn && cfgAddr == 2'd3;
    bit popGo = 0;
    chk("outValid", outValid, expV);
    if (expV) chk("outData", outData, smpData);
    chk("lateErr", lateErr, mLate);
    chk("overrunErr", overrunErr, mOvr);
    chk("underflowErr", underflowErr, mUnd);
    chk("cmdDropped", cmdDropped, mDrop);
    chk("queueCount", queueCount, mq.size());
    nLate = mLate && !clr; nOvr = mOvr && !clr; nUnd = mUnd && !clr; nDrop = mDrop && !clr;
    nCtrl = mCtrl; nSecs = mSecs; nSt = mSt; nTime = mTime; nRem = mRem; nChain = mChain;
    popNow = 0; pushNow = 0;
    if (cfgWrEn && cfgAddr == 2'd0) nCtrl = cfgData;
    if (cfgWrEn && cfgAddr == 2'd1) nSecs = cfgData;
    if (cfgWrEn && cfgAddr == 2'd2) begin
      if (mq.size() == 8) nDrop = 1;
      else begin pushNow = 1; pushVal = {mCtrl, mSecs, cfgData}; end
    end
    case (mSt)
      0: popGo = mq.size() > 0;
      1, 2: begin
        if (active && smpValid && !outReady) begin nOvr = 1; nSt = 3; end
        else begin
          if (active && smpValid) nRem = mRem - 1;
          if (mSt == 1 && reached) nSt = 2;
          else if (mSt == 2 && mRem == 0) begin
            if (!mChain) nSt = 0;
            else if (mq.size() > 0) popGo = 1;
            else begin nUnd = 1; nSt = 3; end
          end
        end
      end
      default: if (clr) nSt = 0;
    endcase
    if (popGo) begin
      logic [95:0] h = mq[0];
      popNow = 1;
      if (h[95]) begin nSt = 2; nTime = h[63:0]; nRem = h[93:64]; nChain = h[94]; end
      else if (h[63:0] < nowv) begin nLate = 1; nSt = 0; end
      else begin nSt = 1; nTime = h[63:0]; nRem = h[93:64]; nChain = h[94]; end
    end
  endtask

  task automatic modelCommit();
    if (popNow) void'(mq.pop_front());
    if (pushNow) mq.push_back(pushVal);
    mCtrl = nCtrl; mSecs = nSecs; mSt = nSt; mTime = nTime; mRem = nRem; mChain = nChain;
    mLate = nLate; mOvr = nOvr; mUnd = nUnd; mDrop = nDrop;
  endtask

  task automatic cycle();
    #5;
    modelEval();
    @(posedge clk);
    modelCommit();
    @(negedge clk);
    cfgWrEn = 0;
    nowTicks = nowTicks + 1;
    smpData = smpData + 1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    cfgWrEn = 1; cfgAddr = a; cfgData = d;
    cycle();
  endtask

  // R2 layout: bit31 immediate, bit30 chain, bits29:0 count
  task automatic pushCmd(bit s, bit c, int n, logic [31:0] secs, logic [31:0] ticks);
    wr(2'd0, {s, c, 30'(n)});
    wr(2'd1, secs);
    wr(2'd2, ticks);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R12 watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 0; cfgWrEn = 0; cfgAddr = 0; cfgData = 0;
    nowSecs = 5; nowTicks = 0; smpValid = 0; smpData = 32'h100; outReady = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    curReq = "R12";
    chk("reset outValid", outValid, 0);
    chk("reset queueCount", queueCount, 0);
    chk("reset flags", {lateErr, overrunErr, underflowErr, cmdDropped}, 0);
    rstN = 1;
    idle(2);

    curReq = "R3"; smpValid = 1;         // R2 and R3: immediate command of 3
    pushCmd(1, 0, 3, 0, 0);
    idle(8);

    curReq = "R4";                       // timed in ticks
    pushCmd(0, 0, 4, 5, nowTicks + 12);
    idle(25);

    curReq = "R4";                       // timed on the seconds word
    pushCmd(0, 0, 2, 6, 0);
    idle(10);
    nowSecs = 6;
    idle(6);

    curReq = "R5";                       // late command then an immediate one
    pushCmd(0, 0, 3, 6, 1);
    pushCmd(1, 0, 2, 0, 0);
    idle(10);

    curReq = "R6";                       // zero count, then gapped samples
    pushCmd(1, 0, 0, 0, 0);
    idle(5);
    pushCmd(1, 0, 6, 0, 0);
    for (int i = 0; i < 20; i++) begin
      smpValid = i[0];
      cycle();
    end
    smpValid = 1;

    curReq = "R7";                       // chained pair staged while the stream is stalled
    smpValid = 0;
    pushCmd(1, 1, 3, 0, 0);
    pushCmd(1, 0, 2, 0, 0);
    smpValid = 1;
    idle(12);

    curReq = "R8";                       // chain into an empty queue
    pushCmd(1, 1, 2, 0, 0);
    idle(6);

    curReq = "R10";                      // fill while halted, one extra push
    for (int i = 0; i < 9; i++) pushCmd(1, 0, 1, 0, 0);
    idle(2);

    curReq = "R11";                      // clear releases the halt and drains the queue
    wr(2'd3, 0);
    idle(24);

    curReq = "R9";                       // overrun
    pushCmd(1, 0, 5, 0, 0);
    idle(2);
    outReady = 0;
    cycle();
    outReady = 1;
    idle(5);
    curReq = "R11";
    wr(2'd3, 0);
    idle(5);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule